// File: doc/BRIEF.md
# Time-Slice Crossbar Arbiter

This block decides which of several agents owns a shared target port. Ownership follows a programmable ring of sixteen time slices. Each slice holds a 4-bit agent code. A slice pointer walks around the ring. When the pointer reaches a slice whose agent is requesting, that agent receives a one-hot grant. The grant is held until the agent signals done, or until an optional hold timer expires. Slices that hold the null code or a reserved code grant nobody. A slice whose agent is idle costs one cycle.

Two 32-bit configuration words carry the ring; each word holds eight slices. A slice's code is read at the moment the pointer evaluates that slice. A change to the configuration while a grant is held therefore has no effect until the next slice is evaluated. The 8-bit hold timer has an active-high off input. When the timer withdraws a grant, it raises a one-cycle flag.

Top module: `slice_ring_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant_o` and `tmo_flag_o` are 0. The first slice evaluated after reset is slice 0.
- R2: Slice n (0..7) is bits [4n+3:4n] of `ring_lo_i`. Slice n (8..15) is bits [4(n-8)+3:4(n-8)] of `ring_hi_i`.
- R3: Codes 0, 1, 3, 4, 5, 6 and 7 name agents. When an evaluated slice holds such a code and `req_i[code]` is 1, `grant_o` equals 1 << code from the next cycle on. At most one bit of `grant_o` is ever set.
- R4: Code 2 (null) and codes 8 to 15 (reserved) grant nobody, even when every request is high. `grant_o[2]` is never set.
- R5: When the evaluated slice grants nobody, the pointer moves to the next slice in the following cycle. Slice 15 is followed by slice 0.
- R6: A grant is held until `done_i[code]` is 1 at a clock edge. The grant is then 0 for one cycle while the next slice is evaluated.
- R7: With `tmo_off_i` = 0 and preset P, a grant stays high for exactly P+1 cycles if done never arrives. The grant is then withdrawn, `tmo_flag_o` is 1 for exactly one cycle with the grant at 0, and the pointer advances.
- R8: With `tmo_off_i` = 1, a grant is never withdrawn by the timer and `tmo_flag_o` stays 0.
- R9: Changes to `ring_lo_i` or `ring_hi_i` while a grant is held leave `grant_o` unchanged. The new codes apply from the next slice evaluation.
- R10: When done arrives in the same cycle the timer would expire, the grant ends as a normal release and `tmo_flag_o` stays 0.
- R11: While a grant is held, the request and done inputs of other agents have no effect on `grant_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request per agent code |
| done_i | input | 8 | End of ownership per agent code |
| ring_lo_i | input | 32 | Codes of slices 0 to 7 |
| ring_hi_i | input | 32 | Codes of slices 8 to 15 |
| tmo_preset_i | input | 8 | Hold timer preset P |
| tmo_off_i | input | 1 | 1 disables the hold timer, 0 enables it |
| grant_o | output | 8 | One-hot grant, bit index is the agent code |
| tmo_flag_o | output | 1 | One-cycle pulse when the timer withdraws a grant |

## Verification
The bench builds the block with its default parameters: a ring of sixteen 4-bit slices, eight code positions and an 8-bit preset. With these values one directed walk covers several cases. It crosses from the low word into the high word and wraps from slice 15 to slice 0. It passes reserved codes 8 and 15 while every request is high. It exercises the timer at presets 0 and 3, and with the timer off. The exact cycle of every grant edge is predicted by counting idle slices between grants. This makes any error in pointer stepping or in timer length show up as a mismatch.

// File: rtl/arb_ring_pkg.sv
package arb_ring_pkg;
  localparam int CODE_W    = 4;
  localparam int RING_LEN  = 16;
  localparam int WORD_W    = 32;
  localparam int PER_WORD  = WORD_W / CODE_W;
  localparam int AGENTS    = 8;
  localparam int NULL_CODE = 2;
  localparam int PTR_W     = $clog2(RING_LEN);
  localparam int AGENT_W   = $clog2(AGENTS);

  typedef logic [CODE_W-1:0] code_t;

  // A code grants only if it names a real agent (not null, not reserved).
  function automatic logic code_grants(input code_t c);
    return (c < code_t'(AGENTS)) && (c != code_t'(NULL_CODE));
  endfunction

  function automatic logic [AGENT_W-1:0] code_agent(input code_t c);
    return c[AGENT_W-1:0];
  endfunction

  function automatic logic [AGENTS-1:0] code_onehot(input code_t c);
    logic [AGENTS-1:0] one;
    one = {{(AGENTS-1){1'b0}}, 1'b1};
    return code_grants(c) ? (one << code_agent(c)) : '0;
  endfunction
endpackage

// File: rtl/arb_slice_sel.sv
module arb_slice_sel
  import arb_ring_pkg::*;
#(
  parameter int RING  = RING_LEN,
  parameter int WIDTH = WORD_W,
  localparam int PW   = $clog2(RING)
) (
  input  logic [WIDTH-1:0] lo_i,
  input  logic [WIDTH-1:0] hi_i,
  input  logic [PW-1:0]    ptr_i,
  output code_t            code_o
);
  localparam int PER = WIDTH / CODE_W;

  code_t table_w [RING];

  for (genvar g = 0; g < RING; g++) begin : g_slice
    if (g < PER) begin : g_low
      assign table_w[g] = lo_i[g*CODE_W +: CODE_W];
    end else begin : g_high
      assign table_w[g] = hi_i[(g-PER)*CODE_W +: CODE_W];
    end
  end

  assign code_o = table_w[ptr_i];
endmodule

// File: rtl/arb_slice_ptr.sv
module arb_slice_ptr #(
  parameter int RING = 16,
  localparam int PW  = $clog2(RING)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(RING - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  // R5: one slice per advance, wrapping at the ring end
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1));
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/arb_hold_timer.sv
module arb_hold_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          off_i,
  input  logic [TW-1:0] preset_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clear_i)                cnt <= '0;
    else if (run_i && cnt != '1)     cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && !off_i && (cnt == preset_i);

  // R7: a new hold always starts counting from zero
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> cnt == '0);
endmodule

// File: rtl/slice_ring_arbiter.sv
module slice_ring_arbiter
  import arb_ring_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGENTS-1:0] req_i,
  input  logic [AGENTS-1:0] done_i,
  input  logic [WORD_W-1:0] ring_lo_i,
  input  logic [WORD_W-1:0] ring_hi_i,
  input  logic [TMO_W-1:0]  tmo_preset_i,
  input  logic              tmo_off_i,
  output logic [AGENTS-1:0] grant_o,
  output logic              tmo_flag_o
);
  logic [PTR_W-1:0]   ptr;
  code_t              cur_code;
  logic [AGENT_W-1:0] hold_agent;
  logic               holding;
  logic               expire;

  // Named internal events
  logic cur_ok, start_hold, done_hit, release_tmo, release_any, slice_adv;

  arb_slice_sel #(.RING(RING_LEN), .WIDTH(WORD_W)) u_sel (
    .lo_i(ring_lo_i), .hi_i(ring_hi_i), .ptr_i(ptr), .code_o(cur_code));

  arb_slice_ptr #(.RING(RING_LEN)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv_i(slice_adv), .ptr_o(ptr));

  arb_hold_timer #(.TW(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear_i(start_hold), .run_i(holding),
    .off_i(tmo_off_i), .preset_i(tmo_preset_i), .expire_o(expire));

  assign cur_ok      = code_grants(cur_code) && req_i[code_agent(cur_code)];
  assign start_hold  = !holding && cur_ok;
  assign done_hit    = holding && done_i[hold_agent];
  assign release_tmo = holding && !done_hit && expire;
  assign release_any = done_hit || release_tmo;
  assign slice_adv   = (!holding && !cur_ok) || release_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holding    <= 1'b0;
      hold_agent <= '0;
      grant_o    <= '0;
      tmo_flag_o <= 1'b0;
    end else begin
      tmo_flag_o <= release_tmo;
      if (start_hold) begin
        holding    <= 1'b1;
        hold_agent <= code_agent(cur_code);
        grant_o    <= code_onehot(cur_code);
      end else if (release_any) begin
        holding <= 1'b0;
        grant_o <= '0;
      end
    end
  end

  // R3: grant is one-hot or empty
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R4: the null position is never granted
  p_null_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_o[NULL_CODE]);
  // R6: done from the owner ends the grant at the next edge
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & done_i) != '0) |=> grant_o == '0);
  // R7: the timeout flag is a single-cycle pulse with no grant
  p_tmo_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag_o |-> grant_o == '0);
  p_tmo_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag_o |=> !tmo_flag_o);
  // R8: timer off means no timeout flag
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_off_i |=> !tmo_flag_o);
  // R9 / R11: a held grant does not move until it is released
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !release_any) |=> $stable(grant_o));
endmodule

// File: tb/slice_ring_arbiter_tb.sv
`timescale 1ns/1ps
module slice_ring_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [7:0]  done = '0;
  logic [31:0] lo = 32'h2222_2223;
  logic [31:0] hi = 32'h2222_2222;
  logic [7:0]  preset = '0;
  logic        off = 1'b1;
  logic [7:0]  grant;
  logic        flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] g;
    logic       f;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  slice_ring_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .ring_lo_i(lo), .ring_hi_i(hi), .tmo_preset_i(preset), .tmo_off_i(off),
    .grant_o(grant), .tmo_flag_o(flag));

  // Monitor: pops one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (grant !== e.g || flag !== e.f) begin
          errors++;
          $display("FAIL %s: grant=%h flag=%b expected grant=%h flag=%b",
                   e.tag, grant, flag, e.g, e.f);
        end
      end
    end
  end

  // Driver: pushes the expectation for the next falling edge
  task automatic expect_out(input logic [7:0] g, input logic f, input string tag);
    sb.push_back('{g: g, f: f, tag: tag});
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    expect_out(8'h00, 1'b0, "R1 reset outputs idle");
    expect_out(8'h00, 1'b0, "R1 reset outputs idle");

    // Slice 0 first after reset, agent 3
    rst_n = 1'b1; req = 8'h08;
    expect_out(8'h08, 1'b0, "R1 R3 slice0 grants agent3");
    repeat (3) expect_out(8'h08, 1'b0, "R6 grant held without done");
    done = 8'h08;
    expect_out(8'h00, 1'b0, "R6 release on done");
    done = '0; req = 8'h40;

    // Slices 1..11 null, slice 12 in high word names agent 6
    lo = 32'h2222_2222; hi = 32'h2226_2222;
    repeat (11) expect_out(8'h00, 1'b0, "R5 null slices step one per cycle");
    expect_out(8'h40, 1'b0, "R2 high word slice12 grants agent6");
    done = 8'h40;
    expect_out(8'h00, 1'b0, "R6 release on done");
    done = '0;

    // Slices 13 (code F), 14 (code 8), 15 (null), then wrap to slice 0
    lo = 32'h2222_2221; hi = 32'h28F2_2222; req = 8'hFF;
    expect_out(8'h00, 1'b0, "R4 reserved code F grants nobody");
    expect_out(8'h00, 1'b0, "R4 reserved code 8 grants nobody");
    expect_out(8'h00, 1'b0, "R4 null code grants nobody");
    expect_out(8'h02, 1'b0, "R5 wrap to slice0 grants agent1");
    done = 8'hFD; req = 8'h00;
    repeat (2) expect_out(8'h02, 1'b0, "R11 other agents done ignored");
    lo = 32'h2222_2251; done = '0; req = 8'hFF;
    repeat (2) expect_out(8'h02, 1'b0, "R9 config change during hold");
    done = 8'h02;
    expect_out(8'h00, 1'b0, "R6 release on done");
    done = '0;
    expect_out(8'h20, 1'b0, "R9 new config used at slice1");
    done = 8'h20;
    expect_out(8'h00, 1'b0, "R6 release on done");
    done = '0;

    // Timeout with preset 3 at slice 2
    lo = 32'h2222_2722; req = 8'h80; preset = 8'd3; off = 1'b0;
    expect_out(8'h80, 1'b0, "R7 grant agent7");
    repeat (3) expect_out(8'h80, 1'b0, "R7 held within preset");
    expect_out(8'h00, 1'b1, "R7 timeout withdraws grant");
    expect_out(8'h00, 1'b0, "R7 flag lasts one cycle");

    // Preset 0 at slice 4
    lo = 32'h2220_2222; req = 8'h01; preset = 8'd0;
    expect_out(8'h01, 1'b0, "R7 preset0 grant one cycle");
    expect_out(8'h00, 1'b1, "R7 preset0 timeout");

    // Done and expiry together at slice 5
    lo = 32'h2242_2222; req = 8'h10;
    expect_out(8'h10, 1'b0, "R10 grant agent4");
    done = 8'h10;
    expect_out(8'h00, 1'b0, "R10 done wins over timeout");
    done = '0;

    // Timer off at slice 6
    lo = 32'h2322_2222; req = 8'h08; off = 1'b1;
    expect_out(8'h08, 1'b0, "R8 grant agent3");
    repeat (10) expect_out(8'h08, 1'b0, "R8 no timeout when off");
    done = 8'h08;
    expect_out(8'h00, 1'b0, "R8 release on done");
    done = '0;

    wait (sb.size() == 0);
    #1;
    finished = 1;
    summary();
  end
endmodule